// File: doc/BRIEF.md
# Tape Command Start Delay Scheduler

This block decides how long a tape drive must wait before it begins a newly issued command, counts that wait down, and then pulses a go signal towards the drive logic. It holds six delay registers: load-point start, command start, gap crossing, inter-record gap, rewind start and per-word transfer time. While no command is running, these registers are reloaded from one of three preset tables. A low-density realistic table, a high-density realistic table and a fast table are available. Fast mode ignores the density input. The inter-record gap and per-word transfer values are not used here. They are brought out for the data-movement logic next to this block.

Commands enter through a valid/ready stream. The scheduler takes one command at a time. `cmd_ready` is high only when no countdown or rewind completion is in progress. A command offered while `cmd_ready` is low is not taken, so the source must keep `cmd_valid` and `cmd_code` steady until it sees a transfer. A transfer is `cmd_valid` and `cmd_ready` high at the same rising edge. The block also tracks two pieces of drive state: whether the tape sits at its load point (BOT) and whether a rewind is under way.

The command code fields this block decodes are: bit 0 (motion), bit 6 (rewind), code 8'o015 (plain gap write) and code 8'o215 (gap followed by file mark).

Top module: `tape_start_sched`

## Requirements
- R1: While idle, the delay registers follow the mode inputs. `fast_mode`=1 selects the fast table whatever `high_density` is. Otherwise `high_density` picks the high-density table (1) or the low-density table (0). Each table lists load-point start, command start, gap crossing, inter-record gap, rewind start and transfer time, in that order:
  - fast: 1, 1000, 1, 1, 100, 10
  - low density: 161512, 14044, 175553, 24885, 878, 88
  - high density: 252800, 17556, 105333, 27387, 878, 44
  
  `irg_time` and `xfer_time` show the inter-record gap and transfer entries.
- R2: A command with bit 6 set uses the rewind start delay alone as its delay.
- R3: For a command with bit 6 clear, the situation part of the delay is chosen in priority order:
  - the load-point start delay when `at_bot` is high;
  - otherwise the gap crossing delay for codes 8'o015 and 8'o215;
  - otherwise zero.
- R4: For a command with bit 6 clear, the command start delay is added to the situation part, except for code 8'o015, which adds nothing. The composed delay appears on `sched_delay` in the cycle after the transfer.
- R5: With composed delay D, `op_fire` is high for exactly one cycle, D cycles after the transfer cycle. `op_code` then holds the transferred code.
- R6: `cmd_ready` stays low from the transfer until the command finishes, including any rewind completion wait. A command offered during that time changes neither the timing, nor `op_code`, nor the drive state.
- R7: Taking a command with bit 0 set and bit 6 clear drops `at_bot` in the next cycle.
- R8: A rewind taken while `at_bot` is low raises `rewinding` in the next cycle. After its `op_fire`, the block waits one command start delay T, then raises `at_bot` and drops `rewinding` T+2 cycles after the `op_fire` cycle. A rewind taken at BOT has no such wait and leaves `rewinding` low.
- R9: After reset the block shows the following state:
  - `at_bot` high;
  - `rewinding`, `op_fire` and `sched_delay` zero;
  - `cmd_ready` high;
  - the fast table loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | Select the fast delay table |
| high_density | input | 1 | Select the high-density realistic table when not fast |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Scheduler can take a command |
| cmd_code | input | 8 | Command code |
| op_fire | output | 1 | One-cycle go pulse to the drive |
| op_code | output | 8 | Code of the command being started |
| sched_delay | output | 24 | Delay composed for the last taken command |
| at_bot | output | 1 | Tape is at its load point |
| rewinding | output | 1 | Rewind in progress |
| irg_time | output | 24 | Current inter-record gap delay |
| xfer_time | output | 24 | Current per-word transfer delay |

## Verification
The main function is exercised with commands chosen to reach every branch of the delay composition:
- a read at BOT (load-point plus base);
- a plain gap away from BOT (gap only, no base);
- gap-plus-mark away from BOT (gap plus base);
- plain reads, writes and spaces away from BOT (base only);
- gap and gap-plus-mark at BOT, where the load-point delay must win over the gap delay.

Each of these is run in more than one table, including fast mode with the density input set, which shows whether density is ignored. Rewinds are issued both away from and at BOT, which separates the completion-wait path from the immediate path. A rewind code offered during a countdown shows whether busy commands are really dropped.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  localparam int CNT_W   = 24;
  localparam int NUM_DLY = 6;
  localparam int CODE_W  = 8;

  localparam int DLY_BOT = 0;
  localparam int DLY_CMD = 1;
  localparam int DLY_GAP = 2;
  localparam int DLY_IRG = 3;
  localparam int DLY_REW = 4;
  localparam int DLY_XFR = 5;

  typedef enum logic [1:0] {
    TBL_LOW  = 2'd0,
    TBL_HIGH = 2'd1,
    TBL_FAST = 2'd2
  } tbl_e;

  localparam int MOTION_BIT = 0;
  localparam int REWIND_BIT = 6;
  localparam logic [CODE_W-1:0] CODE_GAP      = 8'o015;
  localparam logic [CODE_W-1:0] CODE_GAP_MARK = 8'o215;

  function automatic logic [CNT_W-1:0] preset(input tbl_e t, input int idx);
    int v;
    v = 0;
    case (t)
      TBL_LOW: begin
        case (idx)
          DLY_BOT: v = 161512;
          DLY_CMD: v = 14044;
          DLY_GAP: v = 175553;
          DLY_IRG: v = 24885;
          DLY_REW: v = 878;
          default: v = 88;
        endcase
      end
      TBL_HIGH: begin
        case (idx)
          DLY_BOT: v = 252800;
          DLY_CMD: v = 17556;
          DLY_GAP: v = 105333;
          DLY_IRG: v = 27387;
          DLY_REW: v = 878;
          default: v = 44;
        endcase
      end
      default: begin
        case (idx)
          DLY_BOT: v = 1;
          DLY_CMD: v = 1000;
          DLY_GAP: v = 1;
          DLY_IRG: v = 1;
          DLY_REW: v = 100;
          default: v = 10;
        endcase
      end
    endcase
    return CNT_W'(v);
  endfunction
endpackage

// File: rtl/tsched_delay_bank.sv
module tsched_delay_bank
  import tsched_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fast_mode,
  input  logic                            high_density,
  input  logic                            hold,
  output logic [NUM_DLY-1:0][CNT_W-1:0]   dly
);
  tbl_e sel;

  always_comb begin
    if (fast_mode)         sel = TBL_FAST;
    else if (high_density) sel = TBL_HIGH;
    else                   sel = TBL_LOW;
  end

  for (genvar i = 0; i < NUM_DLY; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)     dly[i] <= preset(TBL_FAST, i);
      else if (!hold) dly[i] <= preset(sel, i);
    end
  end
endmodule

// File: rtl/tsched_compose.sv
module tsched_compose
  import tsched_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              bot,
  input  logic [CNT_W-1:0]  t_bot,
  input  logic [CNT_W-1:0]  t_cmd,
  input  logic [CNT_W-1:0]  t_gap,
  input  logic [CNT_W-1:0]  t_rew,
  output logic [CNT_W-1:0]  total,
  output logic              is_rewind,
  output logic              is_motion
);
  logic [CNT_W-1:0] situ;
  logic [CNT_W-1:0] base;
  logic             gap_like;

  assign is_rewind = code[REWIND_BIT];
  assign is_motion = code[MOTION_BIT];
  assign gap_like  = (code == CODE_GAP) || (code == CODE_GAP_MARK);

  always_comb begin
    if (bot)           situ = t_bot;
    else if (gap_like) situ = t_gap;
    else               situ = '0;
    base  = (code == CODE_GAP) ? '0 : t_cmd;
    total = is_rewind ? t_rew : situ + base;
  end
endmodule

// File: rtl/tsched_countdown.sv
module tsched_countdown #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         running,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= load_val;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tape_start_sched.sv
module tape_start_sched
  import tsched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              high_density,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_code,
  output logic              op_fire,
  output logic [7:0]        op_code,
  output logic [23:0]       sched_delay,
  output logic              at_bot,
  output logic              rewinding,
  output logic [23:0]       irg_time,
  output logic [23:0]       xfer_time
);
  logic [NUM_DLY-1:0][CNT_W-1:0] dly;
  logic [CNT_W-1:0] composed;
  logic [CNT_W-1:0] load_val;
  logic is_rewind, is_motion;
  logic running, expire, load, accept, tail_q, tail_end;

  tsched_delay_bank u_bank (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
    .high_density(high_density), .hold(running), .dly(dly)
  );

  tsched_compose u_comp (
    .code(cmd_code), .bot(at_bot),
    .t_bot(dly[DLY_BOT]), .t_cmd(dly[DLY_CMD]),
    .t_gap(dly[DLY_GAP]), .t_rew(dly[DLY_REW]),
    .total(composed), .is_rewind(is_rewind), .is_motion(is_motion)
  );

  assign cmd_ready = !running;
  assign accept    = cmd_valid && cmd_ready;
  assign op_fire   = expire && !tail_q;
  assign tail_end  = expire && tail_q;
  assign load      = accept || (op_fire && rewinding);
  assign load_val  = accept ? composed : dly[DLY_CMD];

  tsched_countdown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .running(running), .expire(expire)
  );

  assign irg_time  = dly[DLY_IRG];
  assign xfer_time = dly[DLY_XFR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_code     <= '0;
      sched_delay <= '0;
      at_bot      <= 1'b1;
      rewinding   <= 1'b0;
      tail_q      <= 1'b0;
    end else begin
      if (accept) begin
        op_code     <= cmd_code;
        sched_delay <= composed;
        if (is_rewind) begin
          if (!at_bot) rewinding <= 1'b1;
        end else if (is_motion) begin
          at_bot <= 1'b0;
        end
      end
      if (op_fire && rewinding) tail_q <= 1'b1;
      if (tail_end) begin
        tail_q    <= 1'b0;
        rewinding <= 1'b0;
        at_bot    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsched_chk.sv
module tsched_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fast_mode,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_code,
  input logic        op_fire,
  input logic [7:0]  op_code,
  input logic [23:0] sched_delay,
  input logic        at_bot,
  input logic        rewinding
);
  // R5
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> !op_fire);

  // R7
  bot_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_code[0] && !cmd_code[6]) |=> !at_bot);

  // R8
  rewind_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_code[6] && !at_bot) |=> rewinding);

  // R8
  bot_after_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_bot) |-> $past(rewinding));

  // R4
  gap_no_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_code == 8'o015 && !at_bot && fast_mode)
      |=> sched_delay == 24'd1);

  // R6
  code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && $past(!cmd_ready)) |-> $stable(op_code));
endmodule

bind tape_start_sched tsched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_code(cmd_code), .op_fire(op_fire),
  .op_code(op_code), .sched_delay(sched_delay), .at_bot(at_bot),
  .rewinding(rewinding)
);

// File: tb/tb_tape_start_sched.sv
`timescale 1ns/1ps
module tb_tape_start_sched;
  logic clk = 1'b0;
  logic rst_n;
  logic fast_mode, high_density, cmd_valid, cmd_ready;
  logic [7:0] cmd_code, op_code;
  logic op_fire, at_bot, rewinding;
  logic [23:0] sched_delay, irg_time, xfer_time;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tape_start_sched dut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .high_density(high_density),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .op_fire(op_fire), .op_code(op_code), .sched_delay(sched_delay),
    .at_bot(at_bot), .rewinding(rewinding), .irg_time(irg_time), .xfer_time(xfer_time)
  );

  typedef struct packed {
    logic        fast;
    logic        hd;
    logic [7:0]  code;
    logic [23:0] delay;
    logic        run;
    logic [23:0] irg;
    logic [23:0] xfr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'o023, 24'd1001,   1'b1, 24'd1,     24'd10},
    '{1'b1, 1'b0, 8'o015, 24'd1,      1'b1, 24'd1,     24'd10},
    '{1'b1, 1'b0, 8'o215, 24'd1001,   1'b1, 24'd1,     24'd10},
    '{1'b1, 1'b0, 8'o031, 24'd1000,   1'b1, 24'd1,     24'd10},
    '{1'b0, 1'b0, 8'o003, 24'd14044,  1'b1, 24'd24885, 24'd88},
    '{1'b0, 1'b1, 8'o003, 24'd17556,  1'b1, 24'd27387, 24'd44},
    '{1'b1, 1'b1, 8'o041, 24'd1000,   1'b1, 24'd1,     24'd10},
    '{1'b1, 1'b0, 8'o101, 24'd100,    1'b1, 24'd1,     24'd10},
    '{1'b1, 1'b0, 8'o101, 24'd100,    1'b1, 24'd1,     24'd10},
    '{1'b0, 1'b0, 8'o015, 24'd161512, 1'b0, 24'd24885, 24'd88},
    '{1'b0, 1'b1, 8'o215, 24'd270356, 1'b0, 24'd27387, 24'd44},
    '{1'b0, 1'b1, 8'o105, 24'd878,    1'b1, 24'd27387, 24'd44},
    '{1'b1, 1'b0, 8'o015, 24'd1,      1'b1, 24'd1,     24'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit model_bot;
    fast_mode = 1'b1;
    high_density = 1'b0;
    cmd_valid = 1'b0;
    cmd_code = 8'h00;
    do_reset();
    @(negedge clk);
    // R9 reset state
    check("R9 at_bot", at_bot, 1);
    check("R9 rewinding", rewinding, 0);
    check("R9 cmd_ready", cmd_ready, 1);
    check("R9 op_fire", op_fire, 0);
    check("R9 sched_delay", sched_delay, 0);
    check("R9 fast irg", irg_time, 1);
    check("R9 fast xfer", xfer_time, 10);
    model_bot = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int n;
      bit tail;
      fast_mode = VECS[i].fast;
      high_density = VECS[i].hd;
      repeat (2) @(negedge clk);
      // R1 table selection
      check($sformatf("R1 irg v%0d", i), irg_time, VECS[i].irg);
      check($sformatf("R1 xfer v%0d", i), xfer_time, VECS[i].xfr);
      check($sformatf("R7 bot before v%0d", i), at_bot, model_bot);
      tail = VECS[i].code[6] && !model_bot;
      cmd_code = VECS[i].code;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      // R2 R3 R4 composed delay
      check($sformatf("R4 delay v%0d", i), sched_delay, VECS[i].delay);
      if (VECS[i].code[0] && !VECS[i].code[6]) begin
        model_bot = 1'b0;
        check($sformatf("R7 bot cleared v%0d", i), at_bot, 0);
      end
      check($sformatf("R8 rewinding v%0d", i), rewinding, tail);
      if (!VECS[i].run) begin
        do_reset();
        model_bot = 1'b1;
        @(negedge clk);
        continue;
      end
      n = 0;
      while (!op_fire && n < 20000) begin
        if (i == 3 && n < 6) begin
          // R6 busy command is dropped
          check("R6 ready low", cmd_ready, 0);
          cmd_code = 8'o101;
          cmd_valid = 1'b1;
        end else begin
          cmd_valid = 1'b0;
          cmd_code = VECS[i].code;
        end
        @(negedge clk);
        n++;
      end
      cmd_valid = 1'b0;
      // R5 fire timing and code
      check($sformatf("R5 cycles v%0d", i), n, VECS[i].delay);
      check($sformatf("R5 op_code v%0d", i), op_code, VECS[i].code);
      if (i == 3) check("R6 no rewind started", rewinding, 0);
      if (tail) begin
        int m = 0;
        while (!at_bot && m < 5000) begin
          @(negedge clk);
          m++;
        end
        // R8 completion wait
        check("R8 bot wait", m, 1002);
        check("R8 rewinding cleared", rewinding, 0);
        model_bot = 1'b1;
      end else begin
        @(negedge clk);
        check($sformatf("R5 single pulse v%0d", i), op_fire, 0);
      end
      check($sformatf("R6 ready after v%0d", i), cmd_ready, 1);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule